// File: doc/BRIEF.md
# Serial Port Sample Rate Generator

This block derives a bit clock and a frame sync for a serial audio port. A reference tick, taken either from every cycle of the system clock or from rising edges of an external clock pin, feeds a programmable divider. Each divided period produces one bit clock period and a one-cycle enable that marks its rising edge. A frame generator counts those bit clocks and produces a frame sync pulse. In period mode the pulse repeats at a programmed period. In word mode the transmitter requests one pulse per word.

The divider and the frame generator have separate active-low resets, so the bit clock can run while frame sync stays off. Configuration is a parallel word. The divider fields are captured on every clock edge while the divider reset is low, and the frame fields while the frame generator is held in reset. After release, changes on the configuration input have no effect. Widths and periods are programmed as the count minus one. For symmetric stereo framing, program a period twice the width, for example fields 31 and 15 for 16-bit words.

Top module: `sample_rate_gen`

## Requirements
- R1: With the divider field `cfg_word[7:0]` = D and the internal source selected (`cfg_word[29]`=1), `bclk_en` is high for one cycle every D+1 clock cycles. `bclk` is high for the first ceil((D+1)/2) cycles of each such period and rises in the cycle where `bclk_en` is high. With D=0, `bclk` stays high.
- R2: While `div_rst_n` is low, `bclk` and `bclk_en` are low. `bclk_en` first goes high in the first cycle after the edge at which `div_rst_n` is seen high.
- R3: With `cfg_word[29]`=0, each rising edge of `ext_clk` that passes through a two-stage synchronizer is one reference tick. With `ext_clk` static, `bclk_en` never rises.
- R4: While `fs_rst_n` or `div_rst_n` is low, `fs` holds its inactive level, which is the value of `fs_pol`.
- R5: In period mode (`cfg_word[28]`=1), frame sync becomes active in the cycle after the first `bclk_en` that the frame generator sees out of reset. It stays active for W+1 bit clocks, with W = `cfg_word[15:8]`, and restarts every P+1 bit clocks without drift, with P = `cfg_word[27:16]`.
- R6: In word mode (`cfg_word[28]`=0), a `word_req` pulse produces exactly one frame sync pulse of W+1 bit clocks. The pulse starts in the cycle after the first `bclk_en` that occurs once the request has been registered. Without a request there is no pulse.
- R7: `fs_pol`=1 inverts `fs` without changing its timing.
- R8: After the resets are released, changes on `cfg_word` do not alter `bclk`, `bclk_en` or `fs`.
- R9: With `div_rst_n` high and `fs_rst_n` low, the bit clock runs while frame sync stays inactive. Releasing `fs_rst_n` later starts framing on the next `bclk_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the internal reference |
| div_rst_n | input | 1 | Synchronous active-low reset of the divider (also holds the frame generator) |
| fs_rst_n | input | 1 | Synchronous active-low reset of the frame generator |
| cfg_word | input | 30 | [7:0] divider, [15:8] width-1, [27:16] period-1, [28] period mode, [29] internal source |
| ext_clk | input | 1 | External reference clock pin |
| word_req | input | 1 | Per-word frame sync request (word mode) |
| fs_pol | input | 1 | 1 makes frame sync active low |
| bclk | output | 1 | Divided bit clock |
| bclk_en | output | 1 | One-cycle strobe coinciding with each bit clock rising edge |
| fs | output | 1 | Frame sync |

## Verification
A wrong divider count appears at `bclk_en` within one bit clock period of release. It then repeats in every period, so sweeping the divider over small values shows both off-by-one and duty-cycle slips within a few cycles. A frame counter that wraps at the wrong point shifts the second frame sync rising edge, so the checks cover at least two full frames. The width, period, late frame release and polarity are each varied so that a stale start flag or a wrong compare changes `fs` in a specific predicted cycle. In word mode, a request flag that is lost or never cleared shows as a missing or extra pulse. The checks therefore also look for `fs` staying quiet before the first request and between requests.

// File: rtl/sample_rate_gen.sv
module sample_rate_gen #(
  parameter int DIV_W = 8,
  parameter int WID_W = 8,
  parameter int PER_W = 12,
  parameter int SYNC_STAGES = 2,
  localparam int WID_LSB = DIV_W,
  localparam int PER_LSB = WID_LSB + WID_W,
  localparam int MODE_BIT = PER_LSB + PER_W,
  localparam int SRC_BIT = MODE_BIT + 1
) (
  input  logic             clk,
  input  logic             div_rst_n,
  input  logic             fs_rst_n,
  input  logic [SRC_BIT:0] cfg_word,
  input  logic             ext_clk,
  input  logic             word_req,
  input  logic             fs_pol,
  output logic             bclk,
  output logic             bclk_en,
  output logic             fs
);

  logic [DIV_W-1:0] div_q;
  logic             src_int_q;
  logic [WID_W-1:0] wid_q;
  logic [PER_W-1:0] per_q;
  logic             per_mode_q;
  logic             fr_run;

  assign fr_run = fs_rst_n & div_rst_n;

  always_ff @(posedge clk) begin
    if (!div_rst_n) begin
      div_q     <= cfg_word[DIV_W-1:0];
      src_int_q <= cfg_word[SRC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!fr_run) begin
      wid_q      <= cfg_word[PER_LSB-1:WID_LSB];
      per_q      <= cfg_word[MODE_BIT-1:PER_LSB];
      per_mode_q <= cfg_word[MODE_BIT];
    end
  end

  // reference tick selection
  logic [SYNC_STAGES:0] ext_sh;
  logic                 ext_rise, ref_tick;

  always_ff @(posedge clk) begin
    if (!div_rst_n) ext_sh <= '0;
    else            ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];
  assign ref_tick = src_int_q | ext_rise;

  // divider: counts down, edge on zero
  logic [DIV_W-1:0] cnt, nxt_cnt;
  logic [DIV_W:0]   half, pos;

  assign nxt_cnt = (cnt == '0) ? div_q : cnt - 1'b1;
  assign half    = ({1'b0, div_q} + (DIV_W+1)'(2)) >> 1;
  assign pos     = {1'b0, div_q} - {1'b0, nxt_cnt};

  always_ff @(posedge clk) begin
    if (!div_rst_n) begin
      cnt     <= '0;
      bclk    <= 1'b0;
      bclk_en <= 1'b0;
    end else if (ref_tick) begin
      cnt     <= nxt_cnt;
      bclk    <= pos < half;
      bclk_en <= cnt == '0;
    end else begin
      bclk_en <= 1'b0;
    end
  end

  // frame generator
  logic [PER_W-1:0] fs_cnt, pcnt, wid_ext;
  logic             fs_act, started, pending;

  assign wid_ext = {{(PER_W-WID_W){1'b0}}, wid_q};
  assign pcnt    = !started ? '0 : (fs_cnt == per_q) ? '0 : fs_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!fr_run) begin
      fs_cnt  <= '0;
      fs_act  <= 1'b0;
      started <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (word_req && !per_mode_q) pending <= 1'b1;
      if (bclk_en) begin
        if (per_mode_q) begin
          started <= 1'b1;
          fs_cnt  <= pcnt;
          fs_act  <= pcnt <= wid_ext;
        end else if (fs_act && fs_cnt < wid_ext) begin
          fs_cnt <= fs_cnt + 1'b1;
        end else if (pending) begin
          fs_cnt  <= '0;
          fs_act  <= 1'b1;
          pending <= word_req;
        end else begin
          fs_act <= 1'b0;
        end
      end
    end
  end

  assign fs = fs_act ^ fs_pol;

  // observation state for the checks below
  logic           fs_prev, seen, req_seen;
  logic [PER_W:0] gap;

  always_ff @(posedge clk) begin
    if (!fr_run) begin
      fs_prev  <= 1'b0;
      seen     <= 1'b0;
      req_seen <= 1'b0;
      gap      <= '0;
    end else begin
      fs_prev <= fs_act;
      if (fs_act && !fs_prev) begin
        seen     <= 1'b1;
        gap      <= bclk_en ? (PER_W+1)'(1) : '0;
        req_seen <= word_req;
      end else begin
        if (bclk_en)  gap      <= gap + 1'b1;
        if (word_req) req_seen <= 1'b1;
      end
    end
  end

  // R2
  div_quiet_chk: assert property (@(posedge clk)
    !div_rst_n |=> (!bclk_en && !bclk));

  // R1
  en_on_rise_chk: assert property (@(posedge clk) disable iff (!div_rst_n)
    bclk_en |-> bclk);

  // R1
  rise_has_en_chk: assert property (@(posedge clk) disable iff (!div_rst_n)
    $rose(bclk) |-> bclk_en);

  // R4
  fs_quiet_chk: assert property (@(posedge clk)
    !fr_run |=> !fs_act);

  // R5
  fs_period_chk: assert property (@(posedge clk) disable iff (!fr_run)
    (per_mode_q && seen && fs_act && !fs_prev) |-> gap == {1'b0, per_q} + (PER_W+1)'(1));

  // R6
  fs_word_req_chk: assert property (@(posedge clk) disable iff (!fr_run)
    (!per_mode_q && fs_act && !fs_prev) |-> req_seen);

endmodule

// File: tb/sample_rate_gen_tb.sv
module sample_rate_gen_tb;

  logic        clk = 1'b0;
  logic        div_rst_n = 1'b0;
  logic        fs_rst_n = 1'b0;
  logic [29:0] cfg_word = '0;
  logic        ext_clk = 1'b0;
  logic        word_req = 1'b0;
  logic        fs_pol = 1'b0;
  logic        bclk, bclk_en, fs;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sample_rate_gen u_dut (
    .clk(clk), .div_rst_n(div_rst_n), .fs_rst_n(fs_rst_n), .cfg_word(cfg_word),
    .ext_clk(ext_clk), .word_req(word_req), .fs_pol(fs_pol),
    .bclk(bclk), .bclk_en(bclk_en), .fs(fs)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [29:0] mk_cfg(int dv, int wd, int pr, bit pmode, bit src);
    return {src, pmode, 12'(pr), 8'(wd), 8'(dv)};
  endfunction

  task automatic hold_reset(logic [29:0] c, bit pol);
    @(negedge clk);
    div_rst_n = 1'b0;
    fs_rst_n  = 1'b0;
    word_req  = 1'b0;
    cfg_word  = c;
    fs_pol    = pol;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 bclk_en in reset", int'(bclk_en), 0);
      chk("R2 bclk in reset", int'(bclk), 0);
      chk("R4 fs in reset", int'(fs), int'(pol));
    end
  endtask

  // period mode run; F = cycle index before which the frame reset stays low
  task automatic run_period(int dv, int wd, int pr, int F, bit pol);
    int n, p, lo, b0, total, chg;
    logic [29:0] c;
    string tg;
    n = dv + 1;
    p = pr + 1;
    lo = (F == 0) ? 0 : F - 1;
    b0 = (lo + n - 1) / n;
    total = n * (b0 + 2 * p + 2);
    chg = (F == 0) ? 2 : F + 1;
    c = mk_cfg(dv, wd, pr, 1'b1, 1'b1);
    hold_reset(c, pol);
    div_rst_n = 1'b1;
    fs_rst_n  = (F == 0);
    for (int t = 0; t < total; t++) begin
      int b;
      bit act;
      @(negedge clk);
      chk(t == 0 ? "R2 first bclk_en" : "R1 bclk_en", int'(bclk_en), int'(t % n == 0));
      chk("R1 bclk", int'(bclk), int'((t % n) < (n + 1) / 2));
      b = (t == 0) ? -1 : (t - 1) / n;
      act = (b >= b0) && (((b - b0) % p) <= wd);
      if (b < b0 && F > 0) tg = "R9 fs before frame release";
      else if (t > chg)    tg = "R8 fs after cfg change";
      else if (pol)        tg = "R7 fs inverted";
      else                 tg = "R5 fs period";
      chk(tg, int'(fs), int'(act ^ pol));
      if (t == F - 1) fs_rst_n = 1'b1;
      if (t == chg)   cfg_word = ~c;
    end
  endtask

  task automatic run_word();
    int n, wd, r1, r2;
    n = 2;
    wd = 2;
    r1 = 10;
    r2 = 30;
    hold_reset(mk_cfg(1, wd, 5, 1'b0, 1'b1), 1'b0);
    div_rst_n = 1'b1;
    fs_rst_n  = 1'b1;
    for (int t = 0; t < 50; t++) begin
      int b, b1, b2;
      bit act;
      @(negedge clk);
      b  = (t == 0) ? -1 : (t - 1) / n;
      b1 = (r1 + n - 1) / n;
      b2 = (r2 + n - 1) / n;
      act = (b >= b1 && b - b1 <= wd) || (b >= b2 && b - b2 <= wd);
      chk("R6 word fs", int'(fs), int'(act));
      word_req = (t == r1 - 1) || (t == r2 - 1);
    end
    word_req = 1'b0;
  endtask

  task automatic run_ext();
    int last, seen_en;
    hold_reset(mk_cfg(1, 3, 40, 1'b1, 1'b0), 1'b0);
    ext_clk = 1'b0;
    div_rst_n = 1'b1;
    fs_rst_n  = 1'b1;
    seen_en = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (bclk_en) seen_en++;
    end
    chk("R3 static ext_clk gives no bclk_en", seen_en, 0);
    last = -1;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (bclk_en) begin
        if (last >= 0) chk("R3 ext bclk_en spacing", t - last, 12);
        last = t;
      end
      if (t % 3 == 2) ext_clk = ~ext_clk;
    end
    chk("R3 ext produced edges", int'(last >= 0), 1);
  endtask

  initial begin
    for (int dv = 0; dv < 5; dv++)
      for (int pi = 0; pi < 2; pi++)
        for (int wd = 0; wd < 3; wd += 2)
          for (int fi = 0; fi < 2; fi++)
            run_period(dv, wd, pi ? 6 : 3, fi ? 7 : 0, 1'((dv + wd) % 2));
    run_period(1, 15, 31, 0, 1'b0);
    run_period(3, 1, 4, 23, 1'b1);
    run_word();
    run_ext();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule